// File: doc/BRIEF.md
# Floating-point/SIMD feature ID read checker

This block sits beside the system-register read path. It decides what a read of the read-only floating-point and SIMD feature identification word returns. Each request carries the current privilege level, whether each level is running in 32-bit or 64-bit state, whether level 2 is enabled, and the control bits that can block or redirect the read. These bits are the coprocessor access field, the non-secure coprocessor permission, the host-extension bit, the floating-point trap and enable controls of a 64-bit hypervisor, the coprocessor trap of a 32-bit hypervisor, and the ID-group trap bits of both hypervisor widths.

The block walks an ordered chain of trap conditions chosen by the privilege level. It reports one of four outcomes: return the word, undefined instruction, trap to a 64-bit hypervisor, or trap to a 32-bit hypervisor. A trap outcome carries an 8-bit syndrome code. Taking the exception and writing the control registers are handled elsewhere.

The two feature fields are fixed by elaboration parameters. A request is accepted in any cycle in which `req_valid` is high. The answer appears one clock later.

Top module: `fpid_access_check`

## Requirements
- R1: The returned word has the SIMD feature field in bits [3:0], the floating-point feature field in bits [7:4], and zero in every bit above; with default parameters a successful read returns 0x00000043.
- R2: The floating-point field parameter accepts only 0 or 4 and the SIMD field parameter only 0 or 3; any other value stops elaboration with an error.
- R3: A request at privilege level 0 always yields outcome 1 (undefined), whatever the control bits hold.
- R4: At level 1, when level 1 is 32-bit and either the coprocessor access field is 00 or the non-secure lock holds, the outcome is undefined, ahead of every trap. The non-secure lock holds when level 3 is 32-bit, the non-secure bit is 1 and the non-secure coprocessor permission is 0. A 64-bit level 1 ignores both conditions.
- R5: At level 1 with level 2 enabled and 64-bit, the outcome is a 64-bit trap with syndrome 0x07 in two cases: host-extension is 0 and the floating-point trap bit is 1, or host-extension is 1 and bit 0 of the 2-bit enable field is 0. Bit 1 of the enable field has no effect.
- R6: At level 1 with level 2 enabled and 32-bit, the non-secure lock or the 32-bit coprocessor trap bit gives a 32-bit trap with syndrome 0x08. The 64-bit hypervisor controls are then ignored.
- R7: At level 1, the ID-group trap of the hypervisor whose width matches level 2 gives a trap with syndrome 0x08, after the checks of R5 and R6. With level 2 disabled, no hypervisor control has any effect.
- R8: At level 2, the order is: the two floating-point conditions of R5 (64-bit trap, 0x07, regardless of level-2 width or enable), then a 32-bit trap with syndrome 0x00 if level 2 is enabled and 32-bit and the lock or 32-bit coprocessor trap holds, else data. ID-group traps and the access field have no effect there.
- R9: At level 3, the outcome is undefined when the coprocessor access field is 00 and data otherwise; hypervisor controls have no effect.
- R10: The outcome is encoded as 0 data, 1 undefined, 2 trap to 64-bit hypervisor, 3 trap to 32-bit hypervisor. The data output is zero unless the outcome is 0, and the syndrome is zero for outcomes 0 and 1.
- R11: Every cycle with `req_valid` high produces exactly one response with `rsp_valid` high on the next cycle, back-to-back included. While `rsp_valid` is low, outcome, syndrome and data are all zero.
- R12: Synchronous active-high `rst` clears `rsp_valid` and all registered outputs on the next edge, overriding a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request this cycle |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| lvl1_is32 | input | 1 | Level 1 runs in 32-bit state |
| lvl2_is32 | input | 1 | Level 2 runs in 32-bit state |
| lvl3_is32 | input | 1 | Level 3 runs in 32-bit state |
| lvl2_on | input | 1 | Level 2 is enabled |
| nonsecure | input | 1 | Non-secure state bit |
| ns_cp_permit | input | 1 | Non-secure coprocessor permission |
| cp_access | input | 2 | Coprocessor access field; 00 denies |
| host_ext | input | 1 | Hypervisor host-extension bit |
| h64_fp_trap | input | 1 | 64-bit hypervisor floating-point trap bit |
| h64_fp_enable | input | 2 | 64-bit hypervisor enable field; bit 0 clear means trap |
| h64_id_trap | input | 1 | 64-bit hypervisor ID-group trap bit |
| h32_cp_trap | input | 1 | 32-bit hypervisor coprocessor trap bit |
| h32_id_trap | input | 1 | 32-bit hypervisor ID-group trap bit |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_outcome | output | 2 | Outcome code |
| rsp_syndrome | output | 8 | Trap syndrome code |
| rsp_data | output | 32 | Returned feature word |

## Verification
A wrong branch order in the chain shows up in the response to the request that sets two competing conditions, one cycle after that request. It appears as the wrong outcome code or syndrome, so the directed cases set pairs of conditions on purpose. A stuck or lost response-valid flag shows either as a missing response one clock after a request, or as nonzero outputs in an idle cycle that follows it. A leak of the feature word into a fault response shows at once on the data lines of that same response.

// File: rtl/fpid_pkg.sv
package fpid_pkg;

    localparam int SYN_W = 8;

    typedef enum logic [1:0] {
        OUT_DATA   = 2'd0,
        OUT_UNDEF  = 2'd1,
        OUT_TRAP64 = 2'd2,
        OUT_TRAP32 = 2'd3
    } outcome_e;

    localparam logic [SYN_W-1:0] SYN_FP_CTRL = 8'h07;
    localparam logic [SYN_W-1:0] SYN_ID_GRP  = 8'h08;
    localparam logic [SYN_W-1:0] SYN_HYP_CP  = 8'h00;

    // Snapshot of everything a request depends on
    typedef struct packed {
        logic [1:0] lvl;
        logic       l1_32;
        logic       l2_32;
        logic       l3_32;
        logic       l2_on;
        logic       ns;
        logic       ns_permit;
        logic [1:0] cp_acc;
        logic       hx;
        logic       h64_fpt;
        logic       h64_en0;
        logic       h64_idt;
        logic       h32_cpt;
        logic       h32_idt;
    } ctx_t;

    typedef struct packed {
        outcome_e         kind;
        logic [SYN_W-1:0] syn;
    } verdict_t;

endpackage

// File: rtl/fpid_word.sv
module fpid_word #(
    parameter int FIELD_W   = 4,
    parameter int DATA_W    = 32,
    parameter int FP_FEAT   = 4,
    parameter int SIMD_FEAT = 3
) (
    output logic [DATA_W-1:0] word
);
    localparam int USED_W = 2 * FIELD_W;
    localparam logic [FIELD_W-1:0] FP_CODE   = FIELD_W'(FP_FEAT);
    localparam logic [FIELD_W-1:0] SIMD_CODE = FIELD_W'(SIMD_FEAT);

    generate
        if (!(FP_FEAT == 0 || FP_FEAT == 4)) begin : g_fp_reserved
            $error("fpid_word: floating-point field value %0d is reserved", FP_FEAT);
        end
        if (!(SIMD_FEAT == 0 || SIMD_FEAT == 3)) begin : g_simd_reserved
            $error("fpid_word: SIMD field value %0d is reserved", SIMD_FEAT);
        end
        if (DATA_W < USED_W || FIELD_W < 3) begin : g_bad_width
            $error("fpid_word: widths cannot hold the feature fields");
        end
    endgenerate

    always_comb begin
        word                       = '0;
        word[FIELD_W-1:0]          = SIMD_CODE;
        word[USED_W-1:FIELD_W]     = FP_CODE;
    end
endmodule

// File: rtl/fpid_guest_rules.sv
// Priority chain for reads issued from privilege level 1
module fpid_guest_rules
    import fpid_pkg::*;
(
    input  ctx_t     ctx,
    input  logic     ns_lock,
    output verdict_t v
);
    logic h64_path;
    logic h32_path;

    always_comb begin
        h64_path = ctx.l2_on && !ctx.l2_32;
        h32_path = ctx.l2_on &&  ctx.l2_32;
        v.kind   = OUT_DATA;
        v.syn    = '0;
        if (ctx.l1_32 && (ns_lock || ctx.cp_acc == 2'b00)) begin
            v.kind = OUT_UNDEF;
        end else if (h64_path && !ctx.hx && ctx.h64_fpt) begin
            v.kind = OUT_TRAP64;
            v.syn  = SYN_FP_CTRL;
        end else if (h64_path && ctx.hx && !ctx.h64_en0) begin
            v.kind = OUT_TRAP64;
            v.syn  = SYN_FP_CTRL;
        end else if (h32_path && (ns_lock || ctx.h32_cpt)) begin
            v.kind = OUT_TRAP32;
            v.syn  = SYN_ID_GRP;
        end else if (h64_path && ctx.h64_idt) begin
            v.kind = OUT_TRAP64;
            v.syn  = SYN_ID_GRP;
        end else if (h32_path && ctx.h32_idt) begin
            v.kind = OUT_TRAP32;
            v.syn  = SYN_ID_GRP;
        end
    end
endmodule

// File: rtl/fpid_hyp_rules.sv
// Priority chain for reads issued from privilege level 2
module fpid_hyp_rules
    import fpid_pkg::*;
(
    input  ctx_t     ctx,
    input  logic     ns_lock,
    output verdict_t v
);
    always_comb begin
        v.kind = OUT_DATA;
        v.syn  = '0;
        if (!ctx.hx && ctx.h64_fpt) begin
            v.kind = OUT_TRAP64;
            v.syn  = SYN_FP_CTRL;
        end else if (ctx.hx && !ctx.h64_en0) begin
            v.kind = OUT_TRAP64;
            v.syn  = SYN_FP_CTRL;
        end else if (ctx.l2_on && ctx.l2_32 && (ns_lock || ctx.h32_cpt)) begin
            v.kind = OUT_TRAP32;
            v.syn  = SYN_HYP_CP;
        end
    end
endmodule

// File: rtl/fpid_access_check.sv
module fpid_access_check
    import fpid_pkg::*;
#(
    parameter int FIELD_W   = 4,
    parameter int DATA_W    = 32,
    parameter int FP_FEAT   = 4,
    parameter int SIMD_FEAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        priv_lvl,
    input  logic              lvl1_is32,
    input  logic              lvl2_is32,
    input  logic              lvl3_is32,
    input  logic              lvl2_on,
    input  logic              nonsecure,
    input  logic              ns_cp_permit,
    input  logic [1:0]        cp_access,
    input  logic              host_ext,
    input  logic              h64_fp_trap,
    input  logic [1:0]        h64_fp_enable,
    input  logic              h64_id_trap,
    input  logic              h32_cp_trap,
    input  logic              h32_id_trap,
    output logic              rsp_valid,
    output logic [1:0]        rsp_outcome,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              vld;
        outcome_e          kind;
        logic [SYN_W-1:0]  syn;
        logic [DATA_W-1:0] data;
    } rsp_t;

    ctx_t              ctx;
    logic              ns_lock;
    logic              enable_hi_unused;
    logic [DATA_W-1:0] id_word;
    verdict_t          v_guest;
    verdict_t          v_hyp;
    verdict_t          v_sel;
    rsp_t              st_d;
    rsp_t              st_q;

    // Bit 1 of the enable field is a don't-care in every rule
    assign enable_hi_unused = h64_fp_enable[1];

    always_comb begin
        ctx.lvl       = priv_lvl;
        ctx.l1_32     = lvl1_is32;
        ctx.l2_32     = lvl2_is32;
        ctx.l3_32     = lvl3_is32;
        ctx.l2_on     = lvl2_on;
        ctx.ns        = nonsecure;
        ctx.ns_permit = ns_cp_permit;
        ctx.cp_acc    = cp_access;
        ctx.hx        = host_ext;
        ctx.h64_fpt   = h64_fp_trap;
        ctx.h64_en0   = h64_fp_enable[0];
        ctx.h64_idt   = h64_id_trap;
        ctx.h32_cpt   = h32_cp_trap;
        ctx.h32_idt   = h32_id_trap;
    end

    // Non-secure side locked out of the coprocessor by a 32-bit monitor
    assign ns_lock = ctx.l3_32 && ctx.ns && !ctx.ns_permit;

    fpid_word #(
        .FIELD_W  (FIELD_W),
        .DATA_W   (DATA_W),
        .FP_FEAT  (FP_FEAT),
        .SIMD_FEAT(SIMD_FEAT)
    ) u_word (
        .word(id_word)
    );

    fpid_guest_rules u_guest (
        .ctx    (ctx),
        .ns_lock(ns_lock),
        .v      (v_guest)
    );

    fpid_hyp_rules u_hyp (
        .ctx    (ctx),
        .ns_lock(ns_lock),
        .v      (v_hyp)
    );

    always_comb begin
        v_sel.kind = OUT_UNDEF;
        v_sel.syn  = '0;
        case (ctx.lvl)
            2'd1:    v_sel = v_guest;
            2'd2:    v_sel = v_hyp;
            2'd3:    v_sel.kind = (ctx.cp_acc == 2'b00) ? OUT_UNDEF : OUT_DATA;
            default: v_sel.kind = OUT_UNDEF;
        endcase
    end

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.vld  = 1'b1;
            st_d.kind = v_sel.kind;
            if (v_sel.kind == OUT_TRAP64 || v_sel.kind == OUT_TRAP32) begin
                st_d.syn = v_sel.syn;
            end
            if (v_sel.kind == OUT_DATA) begin
                st_d.data = id_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.vld;
    assign rsp_outcome  = st_q.kind;
    assign rsp_syndrome = st_q.syn;
    assign rsp_data     = st_q.data;
endmodule

// File: rtl/fpid_access_sva.sv
module fpid_access_sva #(
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int SYN_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        priv_lvl,
    input logic [1:0]        cp_access,
    input logic              rsp_valid,
    input logic [1:0]        rsp_outcome,
    input logic [SYN_W-1:0]  rsp_syndrome,
    input logic [DATA_W-1:0] rsp_data
);
    localparam int USED_W = 2 * FIELD_W;

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_data >> USED_W) == '0);

    p_lvl0_undef_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv_lvl == 2'd0) |=> (rsp_valid && rsp_outcome == 2'd1));

    p_lvl3_deny_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv_lvl == 2'd3 && cp_access == 2'b00) |=> (rsp_outcome == 2'd1));

    p_lvl3_grant_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv_lvl == 2'd3 && cp_access != 2'b00) |=> (rsp_outcome == 2'd0));

    p_trap64_code_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 2'd2) |-> (rsp_syndrome == 8'h07 || rsp_syndrome == 8'h08));

    p_fault_no_data_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_outcome != 2'd0) |-> (rsp_data == '0));

    p_quiet_syn_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_outcome == 2'd0 || rsp_outcome == 2'd1) |-> (rsp_syndrome == '0));

    p_one_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_outcome == 2'd0 && rsp_syndrome == '0 && rsp_data == '0));

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_data == '0 && rsp_outcome == 2'd0));
endmodule

bind fpid_access_check fpid_access_sva #(
    .FIELD_W(FIELD_W),
    .DATA_W (DATA_W),
    .SYN_W  (fpid_pkg::SYN_W)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .priv_lvl    (priv_lvl),
    .cp_access   (cp_access),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .rsp_syndrome(rsp_syndrome),
    .rsp_data    (rsp_data)
);

// File: tb/test_fpid_access_check.sv
module test_fpid_access_check;
    localparam logic [31:0] WORD = 32'h0000_0043;
    localparam logic [1:0]  O_DATA = 2'd0, O_UNDEF = 2'd1, O_T64 = 2'd2, O_T32 = 2'd3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  priv_lvl;
    logic        lvl1_is32, lvl2_is32, lvl3_is32, lvl2_on;
    logic        nonsecure, ns_cp_permit;
    logic [1:0]  cp_access;
    logic        host_ext, h64_fp_trap;
    logic [1:0]  h64_fp_enable;
    logic        h64_id_trap, h32_cp_trap, h32_id_trap;
    logic        rsp_valid;
    logic [1:0]  rsp_outcome;
    logic [7:0]  rsp_syndrome;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fpid_access_check i_fpid_access_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .priv_lvl(priv_lvl),
        .lvl1_is32(lvl1_is32), .lvl2_is32(lvl2_is32), .lvl3_is32(lvl3_is32),
        .lvl2_on(lvl2_on), .nonsecure(nonsecure), .ns_cp_permit(ns_cp_permit),
        .cp_access(cp_access), .host_ext(host_ext), .h64_fp_trap(h64_fp_trap),
        .h64_fp_enable(h64_fp_enable), .h64_id_trap(h64_id_trap),
        .h32_cp_trap(h32_cp_trap), .h32_id_trap(h32_id_trap),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_syndrome(rsp_syndrome), .rsp_data(rsp_data)
    );

    function automatic void check(string tag, logic [42:0] act, logic [42:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual={v,o,syn,data}=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic logic [42:0] resp();
        return {rsp_valid, rsp_outcome, rsp_syndrome, rsp_data};
    endfunction

    // Permissive baseline: level 1, everything 64-bit, level 2 enabled, no traps
    task automatic baseline();
        priv_lvl = 2'd1; lvl1_is32 = 0; lvl2_is32 = 0; lvl3_is32 = 0; lvl2_on = 1;
        nonsecure = 0; ns_cp_permit = 1; cp_access = 2'b11; host_ext = 0;
        h64_fp_trap = 0; h64_fp_enable = 2'b11; h64_id_trap = 0;
        h32_cp_trap = 0; h32_id_trap = 0;
    endtask

    // Single request; response sampled at the negedge after the capturing edge
    task automatic ask(string tag, logic [1:0] eo, logic [7:0] es, logic [31:0] ed);
        @(negedge clk); req_valid = 1;
        @(negedge clk); req_valid = 0;
        check(tag, resp(), {1'b1, eo, es, ed});
    endtask

    task automatic t_reset();
        rst = 1; baseline(); priv_lvl = 2'd3; req_valid = 1;
        repeat (3) @(negedge clk);
        check("R12 outputs clear under reset with request held", resp(), 43'd0);
        req_valid = 0; rst = 0;
        @(negedge clk);
        check("R11 idle after reset", resp(), 43'd0);
    endtask

    task automatic t_level0();
        baseline(); priv_lvl = 2'd0;
        ask("R3 level0 permissive", O_UNDEF, 8'h00, 32'h0);
        h64_fp_trap = 1; cp_access = 2'b00; lvl1_is32 = 1;
        ask("R3 level0 with traps set", O_UNDEF, 8'h00, 32'h0);
    endtask

    task automatic t_level1_undef();
        baseline();
        ask("R1 R2 level1 word 0x43", O_DATA, 8'h00, WORD);
        cp_access = 2'b00;
        ask("R4 64-bit level1 ignores access field", O_DATA, 8'h00, WORD);
        lvl1_is32 = 1;
        ask("R4 32-bit level1 access field 00", O_UNDEF, 8'h00, 32'h0);
        h64_fp_trap = 1; h32_id_trap = 1;
        ask("R4 undefined beats traps", O_UNDEF, 8'h00, 32'h0);
        baseline(); lvl1_is32 = 1; lvl3_is32 = 1; nonsecure = 1; ns_cp_permit = 0;
        ask("R4 non-secure lock", O_UNDEF, 8'h00, 32'h0);
        ns_cp_permit = 1;
        ask("R4 lock released by permission", O_DATA, 8'h00, WORD);
    endtask

    task automatic t_level1_h64();
        baseline(); h64_fp_trap = 1;
        ask("R5 fp trap host-ext 0", O_T64, 8'h07, 32'h0);
        host_ext = 1;
        ask("R5 fp trap ignored with host-ext 1", O_DATA, 8'h00, WORD);
        h64_fp_enable = 2'b10;
        ask("R5 enable x0 pattern 10", O_T64, 8'h07, 32'h0);
        h64_fp_enable = 2'b00;
        ask("R5 enable x0 pattern 00", O_T64, 8'h07, 32'h0);
        h64_fp_enable = 2'b01;
        ask("R5 enable bit1 don't-care 01", O_DATA, 8'h00, WORD);
        baseline(); h64_fp_trap = 1; h64_id_trap = 1;
        ask("R5 fp trap beats ID trap", O_T64, 8'h07, 32'h0);
        h64_fp_trap = 0;
        ask("R7 64-bit ID trap", O_T64, 8'h08, 32'h0);
    endtask

    task automatic t_level1_h32();
        baseline(); lvl2_is32 = 1; h32_cp_trap = 1; h64_fp_trap = 1;
        ask("R6 32-bit cp trap, 64-bit controls ignored", O_T32, 8'h08, 32'h0);
        baseline(); lvl2_is32 = 1; lvl3_is32 = 1; nonsecure = 1; ns_cp_permit = 0;
        ask("R6 32-bit hyp non-secure lock", O_T32, 8'h08, 32'h0);
        baseline(); lvl2_is32 = 1; h32_id_trap = 1; h64_id_trap = 1;
        ask("R7 32-bit ID trap", O_T32, 8'h08, 32'h0);
        baseline(); lvl2_is32 = 1; h64_id_trap = 1;
        ask("R7 64-bit ID trap ignored for 32-bit level2", O_DATA, 8'h00, WORD);
        baseline(); lvl2_on = 0; h64_fp_trap = 1; h64_id_trap = 1; h32_cp_trap = 1;
        h32_id_trap = 1;
        ask("R7 level2 disabled ignores hyp controls", O_DATA, 8'h00, WORD);
    endtask

    task automatic t_level2();
        baseline(); priv_lvl = 2'd2; lvl2_on = 0; lvl2_is32 = 1; h64_fp_trap = 1;
        ask("R8 fp trap regardless of width/enable", O_T64, 8'h07, 32'h0);
        baseline(); priv_lvl = 2'd2; host_ext = 1; h64_fp_enable = 2'b00;
        ask("R8 enable x0", O_T64, 8'h07, 32'h0);
        baseline(); priv_lvl = 2'd2; lvl2_is32 = 1; h32_cp_trap = 1;
        ask("R8 32-bit trap syndrome 00", O_T32, 8'h00, 32'h0);
        lvl2_on = 0;
        ask("R8 32-bit trap needs level2 enabled", O_DATA, 8'h00, WORD);
        baseline(); priv_lvl = 2'd2; h64_id_trap = 1; h32_id_trap = 1; cp_access = 2'b00;
        lvl1_is32 = 1;
        ask("R8 ID traps and access field ignored", O_DATA, 8'h00, WORD);
    endtask

    task automatic t_level3();
        baseline(); priv_lvl = 2'd3; cp_access = 2'b00;
        ask("R9 level3 access 00", O_UNDEF, 8'h00, 32'h0);
        cp_access = 2'b01; h64_fp_trap = 1; h32_cp_trap = 1; lvl2_is32 = 1;
        ask("R9 level3 hyp controls ignored", O_DATA, 8'h00, WORD);
    endtask

    task automatic t_stream();
        baseline();
        @(negedge clk); req_valid = 1; priv_lvl = 2'd0;
        @(negedge clk);
        check("R11 back-to-back first", resp(), {1'b1, O_UNDEF, 8'h00, 32'h0});
        priv_lvl = 2'd3;
        @(negedge clk);
        check("R11 back-to-back second", resp(), {1'b1, O_DATA, 8'h00, WORD});
        priv_lvl = 2'd1; h64_id_trap = 1;
        @(negedge clk);
        check("R11 back-to-back third", resp(), {1'b1, O_T64, 8'h08, 32'h0});
        req_valid = 0;
        @(negedge clk);
        check("R11 idle after stream", resp(), 43'd0);
        baseline(); priv_lvl = 2'd3; req_valid = 1;
        @(negedge clk);
        check("R10 data before reset", resp(), {1'b1, O_DATA, 8'h00, WORD});
        rst = 1;
        @(negedge clk);
        check("R12 reset overrides request", resp(), 43'd0);
        rst = 0; req_valid = 0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_level0();
        t_level1_undef();
        t_level1_h64();
        t_level1_h32();
        t_level2();
        t_level3();
        t_stream();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule